// File: doc/BRIEF.md
# Multi-Standard Audio Serial Transmitter

This block is the master-side transmitter of a stereo or mono audio link. It takes parallel samples through a valid/ready handshake and produces three lines: a bit clock, a word-select or frame-sync line, and serial data. Four framings can be chosen at run time with a 2-bit standard input: Philips-style, left-aligned, right-aligned and PCM. In PCM mode the sync can be a one-bit pulse or a long pulse. The bit-clock idle level, the sample width and the slot width can be set independently.

The block has no clock divider. A one-cycle `bclk_tick` pulse from outside steps the bit clock by half a period, so one transmitted bit takes two ticks. All configuration inputs are copied into internal registers only while `enable` is low. When `enable` rises, the block sends one lead-in bit and then starts the first frame.

Top module: `aud_serial_tx`

## Requirements
- R1: `cfg_std` = 00 selects Philips framing. Word select is 0 during left slots and 1 during right slots, and it takes the new slot's level on the last bit of the previous slot. The MSB therefore goes out one bit after word select changes.
- R2: `cfg_std` = 01 selects left-aligned framing. Word select equals the slot's channel and changes on the MSB bit. Bit b of a slot carries sample bit (DL-1-b) for b < DL and 0 from then to the end of the slot.
- R3: `cfg_std` = 10 selects right-aligned framing. Bit b of a slot carries sample bit (CH-1-b) when b ≥ CH-DL and 0 otherwise, so the LSB is the last bit of the slot.
- R4: `cfg_std` = 11 selects PCM. Each frame is one slot of CH bits and carries only the `s_left` sample, placed as in R2. With `cfg_pcm_long` = 0 the sync is 1 only on the last bit of a frame, which is the bit before the MSB. With `cfg_pcm_long` = 1 the sync is 1 on bits 0 to 12 of the frame. `cfg_pcm_long` has no effect for the other standards.
- R5: `cfg_dlen` sets DL: 00 gives 16 bits, 01 gives 24, 10 gives 32 and 11 gives 16. `cfg_chlen` = 0 gives CH = 16 and 1 gives CH = 32, but CH is 32 whenever DL exceeds 16. A sample is taken from the low DL bits of its input, and the MSB goes out first.
- R6: `sck` rests at `cfg_cpol`. A tick at rest drives it to the active level, and the next tick brings it back to rest and moves to the next bit. `sd` and `ws` change only when `sck` returns to rest.
- R7: Standard, PCM sync length, mode, polarity and both lengths are captured only while `enable` is low. Changes made while enabled have no effect until the next disable.
- R8: `cfg_mode` = 10 (master transmit) is the only mode that runs. Any other value sets `unsupported`. While unsupported, `sck` stays at rest, `sd` stays low and `s_ready` stays low even with `enable` high.
- R9: While `enable` is low, `sd` is 0 and `sck` is at the polarity level.
- R10: `s_ready` pulses for one cycle, coincident with a tick, when a new frame begins. A sample pair is taken in that cycle if `s_valid` is high.
- R11: If `s_valid` is low at a frame start, the frame sends zeros and `underrun` goes high. `underrun` stays high until `enable` falls.
- R12: After `enable` rises, the first active `sck` transition carries one lead-in bit with `sd` = 0. On that bit, word select has the value that would precede the first frame's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_tick | input | 1 | Half-bit-period step pulse |
| enable | input | 1 | Run enable; configuration is captured while low |
| cfg_std | input | 2 | Framing standard select |
| cfg_pcm_long | input | 1 | PCM long sync select |
| cfg_mode | input | 2 | Operating mode; only 10 is supported |
| cfg_cpol | input | 1 | Bit-clock idle level |
| cfg_dlen | input | 2 | Sample length code |
| cfg_chlen | input | 1 | Slot length code |
| s_valid | input | 1 | Sample pair available |
| s_ready | output | 1 | Sample pair taken this cycle when valid |
| s_left | input | 32 | Left sample (PCM sample), right-aligned |
| s_right | input | 32 | Right sample, right-aligned |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky missing-sample flag |
| unsupported | output | 1 | Captured mode is not master transmit |

## Verification
The bench runs every framing, every PCM sync length, all data lengths, both slot lengths and both polarities. It checks `sd` and `ws` at every active clock edge against a model built from the slot formulas. The slot-boundary bits show which framing faults occurred: a Philips word select that moves together with the MSB, a right-aligned LSB that lands one bit early, or a PCM sync that is too long or in the wrong place. A data length above 16 with a short slot requested exposes a design that fails to widen the slot, since it truncates samples. Each run scrambles the configuration inputs after enabling, so a design that keeps tracking them changes its framing mid-stream. The lead-in bit, missing samples and unsupported modes are also exercised; a wrong design here would start the MSB early, keep a stale sample, or toggle the clock.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'b00,
        STD_MSBJ    = 2'b01,
        STD_LSBJ    = 2'b10,
        STD_PCM     = 2'b11
    } std_e;

    typedef enum logic [1:0] {
        MODE_STX = 2'b00,
        MODE_SRX = 2'b01,
        MODE_MTX = 2'b10,
        MODE_MRX = 2'b11
    } mode_e;

    typedef struct packed {
        std_e       std;
        logic       pcm_long;
        logic       cpol;
        logic [1:0] dlen;
        logic       chlen;
        mode_e      mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        std:      STD_PHILIPS,
        pcm_long: 1'b0,
        cpol:     1'b0,
        dlen:     2'b00,
        chlen:    1'b0,
        mode:     MODE_MTX
    };

    // Sample length in bits for a length code, given the widest sample.
    function automatic int unsigned data_bits(input logic [1:0] code, input int unsigned w);
        int unsigned r;
        case (code)
            2'b01:   r = (w * 3) / 4;
            2'b10:   r = w;
            default: r = w / 2;
        endcase
        return r;
    endfunction

    // Slot length: short slot only when the sample fits in it.
    function automatic int unsigned slot_bits(input logic chlen, input logic [1:0] dlen,
                                              input int unsigned w);
        int unsigned r;
        if (chlen || (data_bits(dlen, w) > w / 2)) r = w;
        else r = w / 2;
        return r;
    endfunction

endpackage

// File: rtl/audtx_cfg.sv
module audtx_cfg
    import audtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] std_i,
    input  logic       pcm_long_i,
    input  logic [1:0] mode_i,
    input  logic       cpol_i,
    input  logic [1:0] dlen_i,
    input  logic       chlen_i,
    output cfg_t       cfg_q,
    output logic       run,
    output logic       unsupported
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (!enable) begin
            cfg_q.std      <= std_e'(std_i);
            cfg_q.pcm_long <= pcm_long_i;
            cfg_q.mode     <= mode_e'(mode_i);
            cfg_q.cpol     <= cpol_i;
            cfg_q.dlen     <= dlen_i;
            cfg_q.chlen    <= chlen_i;
        end
    end

    always_comb begin
        unsupported = (cfg_q.mode != MODE_MTX);
        run         = enable && !unsupported;
    end

    // R7: captured configuration does not move while running
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(cfg_q));

endmodule

// File: rtl/audtx_seq.sv
module audtx_seq #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          pcm,
    input  logic [CW-1:0] ch,
    output logic          ph_q,
    output logic          adv,
    output logic          frame_start,
    output logic [CW-1:0] bit_n,
    output logic          slot_n
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] bit_q;
    logic          slot_q;
    logic          wrap;

    always_comb begin
        adv         = run && tick && ph_q;
        wrap        = (bit_q == ch - ONE);
        bit_n       = wrap ? '0 : bit_q + ONE;
        slot_n      = wrap ? (pcm ? 1'b0 : ~slot_q) : slot_q;
        frame_start = adv && wrap && !slot_n;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q   <= 1'b0;
            bit_q  <= ch - ONE;
            slot_q <= !pcm;
        end else if (tick) begin
            ph_q <= !ph_q;
            if (ph_q) begin
                bit_q  <= bit_n;
                slot_q <= slot_n;
            end
        end
    end

    // R5: bit position stays inside the slot length
    p_bit_range_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> (bit_q < ch));

    // R4: PCM frames never move to a right slot
    p_pcm_single_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (run && pcm && $past(run)) |-> !slot_q);

endmodule

// File: rtl/audtx_ser.sv
module audtx_ser
    import audtx_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 32,
    parameter int unsigned CW        = 6,
    parameter int unsigned LONG_SYNC = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                adv,
    input  logic                frame_start,
    input  logic [CW-1:0]       bit_n,
    input  logic                slot_n,
    input  cfg_t                cfg,
    input  logic [CW-1:0]       dl,
    input  logic [CW-1:0]       ch,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                sd_q,
    output logic                ws_q,
    output logic                underrun
);

    localparam int unsigned   IW    = $clog2(SAMPLE_W);
    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] LSYNC = CW'(LONG_SYNC);

    logic [SAMPLE_W-1:0] left_q, right_q, word_n;
    logic [CW-1:0]       last;
    logic                pcm, sd_n, ws_n, ws_idle;

    function automatic logic ws_level(input std_e std, input logic long_sync,
                                      input logic [CW-1:0] b, input logic s,
                                      input logic [CW-1:0] lst);
        logic r;
        case (std)
            STD_PHILIPS: r = (b == lst) ? ~s : s;
            STD_PCM:     r = long_sync ? (b < LSYNC) : (b == lst);
            default:     r = s;
        endcase
        return r;
    endfunction

    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] w, input std_e std,
                                      input logic [CW-1:0] b, input logic [CW-1:0] dlen,
                                      input logic [CW-1:0] clen);
        logic [CW-1:0] idx;
        logic          hit;
        if (std == STD_LSBJ) begin
            hit = (b >= clen - dlen);
            idx = clen - ONE - b;
        end else begin
            hit = (b < dlen);
            idx = dlen - ONE - b;
        end
        return hit ? w[idx[IW-1:0]] : 1'b0;
    endfunction

    always_comb begin
        pcm     = (cfg.std == STD_PCM);
        last    = ch - ONE;
        if (frame_start) word_n = s_valid ? s_left : '0;
        else             word_n = slot_n ? right_q : left_q;
        sd_n    = pick_bit(word_n, cfg.std, bit_n, dl, ch);
        ws_n    = ws_level(cfg.std, cfg.pcm_long, bit_n, slot_n, last);
        ws_idle = ws_level(cfg.std, cfg.pcm_long, last, !pcm, last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_q     <= 1'b0;
            ws_q     <= 1'b0;
            left_q   <= '0;
            right_q  <= '0;
            underrun <= 1'b0;
        end else if (!run) begin
            sd_q     <= 1'b0;
            ws_q     <= ws_idle;
            underrun <= 1'b0;
        end else if (adv) begin
            sd_q <= sd_n;
            ws_q <= ws_n;
            if (frame_start) begin
                left_q   <= s_valid ? s_left  : '0;
                right_q  <= s_valid ? s_right : '0;
                underrun <= underrun | !s_valid;
            end
        end
    end

    // R10: a sample request lasts one cycle
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R11: underrun holds until the block stops
    p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(underrun)) |-> underrun);

    // R4: short PCM sync lasts a single bit
    p_pcm_short_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (run && pcm && !cfg.pcm_long && ws_q && adv) |=> !ws_q);

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import audtx_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 32,
    parameter int unsigned LONG_SYNC = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_tick,
    input  logic                enable,
    input  logic [1:0]          cfg_std,
    input  logic                cfg_pcm_long,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_cpol,
    input  logic [1:0]          cfg_dlen,
    input  logic                cfg_chlen,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                sck,
    output logic                ws,
    output logic                sd,
    output logic                underrun,
    output logic                unsupported
);

    localparam int unsigned CW = $clog2(SAMPLE_W) + 1;

    cfg_t          cfg_q;
    logic          run, pcm;
    logic [CW-1:0] dl, ch, bit_n;
    logic          ph_q, adv, frame_start, slot_n, sd_q, ws_q;

    audtx_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .std_i       (cfg_std),
        .pcm_long_i  (cfg_pcm_long),
        .mode_i      (cfg_mode),
        .cpol_i      (cfg_cpol),
        .dlen_i      (cfg_dlen),
        .chlen_i     (cfg_chlen),
        .cfg_q       (cfg_q),
        .run         (run),
        .unsupported (unsupported)
    );

    always_comb begin
        dl  = CW'(data_bits(cfg_q.dlen, SAMPLE_W));
        ch  = CW'(slot_bits(cfg_q.chlen, cfg_q.dlen, SAMPLE_W));
        pcm = (cfg_q.std == STD_PCM);
    end

    audtx_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .tick        (bclk_tick),
        .pcm         (pcm),
        .ch          (ch),
        .ph_q        (ph_q),
        .adv         (adv),
        .frame_start (frame_start),
        .bit_n       (bit_n),
        .slot_n      (slot_n)
    );

    audtx_ser #(.SAMPLE_W(SAMPLE_W), .CW(CW), .LONG_SYNC(LONG_SYNC)) u_ser (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .adv         (adv),
        .frame_start (frame_start),
        .bit_n       (bit_n),
        .slot_n      (slot_n),
        .cfg         (cfg_q),
        .dl          (dl),
        .ch          (ch),
        .s_valid     (s_valid),
        .s_left      (s_left),
        .s_right     (s_right),
        .sd_q        (sd_q),
        .ws_q        (ws_q),
        .underrun    (underrun)
    );

    always_comb begin
        s_ready = frame_start;
        sck     = cfg_q.cpol ^ (run & ph_q);
        sd      = sd_q & run;
        ws      = ws_q;
    end

    // R6: data only moves while the bit clock is at rest
    p_data_on_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(sd)) |-> (sck == cfg_q.cpol));

    // R8: unsupported mode keeps the link quiet
    p_unsup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> (!s_ready && !sd && sck == cfg_q.cpol));

endmodule

// File: tb/aud_serial_tx_bench.sv
module aud_serial_tx_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_tick = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  cfg_std = 2'b00;
    logic        cfg_pcm_long = 1'b0;
    logic [1:0]  cfg_mode = 2'b10;
    logic        cfg_cpol = 1'b0;
    logic [1:0]  cfg_dlen = 2'b00;
    logic        cfg_chlen = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_left = '0;
    logic [31:0] s_right = '0;
    logic        sck, ws, sd, underrun, unsupported;

    int n_chk = 0;
    int n_bad = 0;
    int idx = 0;
    int b_std, b_long, b_dl, b_ch, b_fl, b_cpol;
    bit b_zero = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_tx u_aud_serial_tx (
        .clk(clk), .rst(rst), .bclk_tick(bclk_tick), .enable(enable),
        .cfg_std(cfg_std), .cfg_pcm_long(cfg_pcm_long), .cfg_mode(cfg_mode),
        .cfg_cpol(cfg_cpol), .cfg_dlen(cfg_dlen), .cfg_chlen(cfg_chlen),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .sck(sck), .ws(ws), .sd(sd), .underrun(underrun), .unsupported(unsupported)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] samp(input int f, input int s);
        logic [31:0] base;
        base = 32'h7E3A_1C05 ^ (32'(f) * 32'h0001_9F3B);
        return s ? ({base[15:0], base[31:16]} ^ 32'hA5C3_0F96) : base;
    endfunction

    // Position of active edge k: k = 0 is the lead-in bit (R12)
    task automatic pos(input int k, output int f, output int s, output int b);
        int p, q;
        if (k == 0) begin
            f = -1; s = (b_std == 3) ? 0 : 1; b = b_ch - 1;
        end else begin
            p = k - 1; f = p / b_fl; q = p % b_fl; s = q / b_ch; b = q % b_ch;
        end
    endtask

    function automatic logic exp_ws(input int s, input int b);
        case (b_std)
            0:       return (b == b_ch - 1) ? logic'(!s) : logic'(s);
            3:       return b_long ? (b < 13) : (b == b_ch - 1);
            default: return logic'(s);
        endcase
    endfunction

    function automatic logic exp_sd(input int k, input int f, input int s, input int b);
        logic [31:0] w;
        if (k == 0 || b_zero) return 1'b0;
        w = samp(f, s);
        if (b_std == 2) return (b >= b_ch - b_dl) ? w[b_ch - 1 - b] : 1'b0;
        return (b < b_dl) ? w[b_dl - 1 - b] : 1'b0;
    endfunction

    function automatic string std_tag(input int k);
        if (k == 0) return "R12";
        case (b_std)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_stream(input int nbits);
        int k = 0;
        int cyc = 0;
        int f, s, b;
        logic acc = 1'b0;
        logic prev_sck = sck;
        logic prev_sd = sd;
        while (k < nbits) begin
            @(posedge clk); #1;
            if (acc) begin
                idx++;
                s_left = samp(idx, 0);
                s_right = samp(idx, 1);
            end
            if (sck !== prev_sck && sck === logic'(!b_cpol)) begin
                pos(k, f, s, b);
                chk(sd === exp_sd(k, f, s, b),
                    $sformatf("%s/R5/R7 sd edge %0d", std_tag(k), k), 32'(sd),
                    32'(exp_sd(k, f, s, b)));
                chk(ws === exp_ws(s, b),
                    $sformatf("%s/R7 ws edge %0d", std_tag(k), k), 32'(ws), 32'(exp_ws(s, b)));
                chk(sd === prev_sd, "R6 sd stable at active edge", 32'(sd), 32'(prev_sd));
                k++;
            end
            prev_sck = sck;
            prev_sd = sd;
            cyc++;
            bclk_tick = cyc[0];
            @(negedge clk);
            acc = s_valid && s_ready;
        end
        @(posedge clk); #1;
        bclk_tick = 1'b0;
    endtask

    task automatic setup(input int st, input int lg, input int dlc, input int chc, input int cp);
        enable = 1'b0;
        bclk_tick = 1'b0;
        cfg_std = 2'(st); cfg_pcm_long = 1'(lg); cfg_dlen = 2'(dlc);
        cfg_chlen = 1'(chc); cfg_cpol = 1'(cp); cfg_mode = 2'b10;
        b_std = st; b_long = lg; b_cpol = cp;
        b_dl = (dlc == 1) ? 24 : (dlc == 2) ? 32 : 16;
        b_ch = (chc == 1 || b_dl > 16) ? 32 : 16;
        b_fl = (st == 3) ? b_ch : 2 * b_ch;
        idx = 0;
        s_left = samp(0, 0);
        s_right = samp(0, 1);
        repeat (3) @(posedge clk);
        #1;
        // R9: idle outputs while disabled
        chk(sd === 1'b0, "R9 sd low while disabled", 32'(sd), 0);
        chk(sck === 1'(cp), "R9 sck at polarity while disabled", 32'(sck), 32'(cp));
    endtask

    task automatic do_cfg(input int st, input int lg, input int dlc, input int chc, input int cp);
        setup(st, lg, dlc, chc, cp);
        s_valid = 1'b1;
        b_zero = 1'b0;
        enable = 1'b1;
        // R7: scramble the inputs while running
        cfg_std = ~cfg_std; cfg_pcm_long = ~cfg_pcm_long; cfg_cpol = ~cfg_cpol;
        cfg_dlen = cfg_dlen ^ 2'b01; cfg_chlen = ~cfg_chlen; cfg_mode = 2'b01;
        run_stream(1 + 3 * b_fl);
        chk(idx == 3, "R10 one sample taken per frame", 32'(idx), 3);
        chk(underrun === 1'b0, "R11 no underrun with valid data", 32'(underrun), 0);
        enable = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int errs;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(sd === 1'b0, "R9 reset sd", 32'(sd), 0);
        chk(sck === 1'b0, "R6 reset sck idle", 32'(sck), 0);
        chk(underrun === 1'b0, "R11 reset underrun", 32'(underrun), 0);
        chk(unsupported === 1'b0, "R8 reset unsupported", 32'(unsupported), 0);
        chk(s_ready === 1'b0, "R10 reset ready", 32'(s_ready), 0);

        for (int st = 0; st < 4; st++)
            for (int lg = 0; lg < ((st == 3) ? 2 : 1); lg++)
                for (int dlc = 0; dlc < 3; dlc++)
                    for (int chc = 0; chc < 2; chc++)
                        for (int cp = 0; cp < 2; cp++)
                            do_cfg(st, lg, dlc, chc, cp);

        // R4: long-sync input set under a non-PCM standard has no effect
        do_cfg(1, 1, 0, 0, 0);

        // R11: missing samples give zeros and a sticky flag
        setup(1, 0, 0, 0, 0);
        s_valid = 1'b0;
        b_zero = 1'b1;
        enable = 1'b1;
        run_stream(1 + 2 * b_fl);
        chk(underrun === 1'b1, "R11 underrun raised", 32'(underrun), 1);
        enable = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(underrun === 1'b0, "R11 underrun cleared by disable", 32'(underrun), 0);
        b_zero = 1'b0;
        s_valid = 1'b1;

        // R8: unsupported modes stay quiet
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            setup(0, 0, 0, 0, 1);
            cfg_mode = 2'(m);
            repeat (2) @(posedge clk);
            #1;
            chk(unsupported === 1'b1, "R8 unsupported flagged", 32'(unsupported), 1);
            enable = 1'b1;
            errs = 0;
            for (int c = 0; c < 40; c++) begin
                bclk_tick = 1'(c % 2);
                @(negedge clk);
                if (s_ready !== 1'b0) errs++;
                @(posedge clk); #1;
                if (sck !== 1'b1 || sd !== 1'b0) errs++;
            end
            bclk_tick = 1'b0;
            chk(errs == 0, "R8 outputs quiet in unsupported mode", 32'(errs), 0);
            enable = 1'b0;
        end
        cfg_mode = 2'b10;
        repeat (2) @(posedge clk);
        #1;
        chk(unsupported === 1'b0, "R8 flag clears with master transmit", 32'(unsupported), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule